// File: doc/BRIEF.md
# Cascaded Interrupt Source Mapper

This block gathers 128 level interrupt sources into one 128-bit status view. The view is split into two 64-bit halves. Sources 0 to 63 form the high half and sources 64 to 127 form the low half. Each source has a mask bit and a 3-bit destination code. Every unmasked asserted source drives one of eight registered destination lines: six ordinary processor interrupt lines, a nonmaskable line and a debug line. Bit 0 of the high half is not a source of its own. It summarises the whole low half, so a processor can route the low half as a group through a single entry.

Inbound interrupt messages carry an 8-bit vector. The top two bits of the vector choose one of four targets: a sticky bit in the high half, a sticky bit in the low half, or one bit in one of two four-bit mailbox groups. The mailbox groups sit at high-half positions 56 to 63. Software clears mailbox bits by writing ones to the high status register.

The configuration is reached through a 64-bit register port with registered read data. Address bit 12 selects the half, so each low-half register lies 0x1000 above its high-half partner.

Top module: `irq_route_hub`

## Requirements
- R1: After reset, every mask bit is 1, every destination code is 0, every sticky and mailbox bit is 0, and `dest_o` is 0.
- R2: Register addresses are 8-byte aligned, and address bit 12 selects the half (0 = high, 1 = low). Within a half, offset 0x000 is status, offset 0x008 is mask, and offset 0x200 + 8*p is the destination code of position p, held in data bits [2:0]. Any other offset reads 0. Read data appears on `rdata_o` one clock after the read request and is held until the next read.
- R3: Bit 0 of the high status register reads as the OR of all 64 low-half status bits. `src_i[0]` and any message aimed at high position 0 have no effect on it.
- R4: Status bit p of the high half is `src_i[p]` OR its sticky bit. Status bit p of the low half is `src_i[64+p]` OR its sticky bit.
- R5: A mask bit of 1 blocks its source. A mask write replaces all 64 mask bits of the addressed half.
- R6: `dest_o[k]` is the OR of every unmasked status bit, the cascade bit included, whose destination code equals k. Code 6 is the nonmaskable line and code 7 is the debug line.
- R7: `dest_o` is registered. A change on `src_i` shows on `dest_o` after exactly one rising clock edge.
- R8: A message whose vector bits [7:6] are 00 sets the sticky bit of high position vec[5:0]. Bits 10 set the sticky bit of low position vec[5:0]. Sticky bits never become set without a message.
- R9: A message whose vector bits [7:6] are 01 sets mailbox bit 56 + vec[1:0]. Bits 11 set mailbox bit 60 + vec[1:0].
- R10: A write to the high status register clears the high bits 56 to 63 where the write data holds 1. It changes no other bit. Writes to the low status register are ignored. When a message sets a bit in the same cycle that a write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 128 | Level interrupt sources, bit n is source n |
| msg_valid_i | input | 1 | Inbound interrupt message strobe |
| msg_vec_i | input | 8 | Inbound message vector |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Register byte address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Registered read data |
| dest_o | output | 8 | Destination lines, index = destination code |

## Verification
The assertions check these properties on every cycle:
- masks change only on a mask write;
- a fully masked block produces no destination output on the next cycle;
- sticky bits never grow without a message;
- a high status read returns the low-half summary in bit 0;
- a low status write leaves the low sticky bits alone;
- a mailbox clear takes effect unless a message sets the same bit in that cycle.

Only the bench scenarios can show the rest. Random mask, map and source patterns are compared against a reference of the OR trees. Directed cases cover the four vector prefixes, the 0x1000 half offset, the one-cycle latency, and a clear and a set that collide on the same mailbox bit.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int HALF_W  = 64;
    localparam int NUM_SRC = 2 * HALF_W;
    localparam int POS_W   = $clog2(HALF_W);
    localparam int IDX_W   = POS_W + 1;
    localparam int MAP_W   = 3;
    localparam int DEST_N  = 1 << MAP_W;
    localparam int VEC_W   = 8;
    localparam int ADDR_W  = 13;
    localparam int DATA_W  = 64;
    localparam int MBX_N   = 8;
    localparam int MBX_GRP = 4;
    localparam int MBX_BASE = HALF_W - MBX_N;

    typedef enum logic [1:0] {
        PFX_HI   = 2'b00,
        PFX_MBX0 = 2'b01,
        PFX_LO   = 2'b10,
        PFX_MBX1 = 2'b11
    } vec_pfx_e;

    typedef enum logic [1:0] {
        RG_STATUS,
        RG_MASK,
        RG_MAP,
        RG_NONE
    } reg_kind_e;

    typedef struct packed {
        logic             half;
        reg_kind_e        kind;
        logic [POS_W-1:0] pos;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.half = a[ADDR_W-1];
        s.pos  = a[3 +: POS_W];
        if (a[ADDR_W-2:0] == 12'h000)
            s.kind = RG_STATUS;
        else if (a[ADDR_W-2:0] == 12'h008)
            s.kind = RG_MASK;
        else if (a[ADDR_W-2:ADDR_W-4] == 3'b001)
            s.kind = RG_MAP;
        else
            s.kind = RG_NONE;
        return s;
    endfunction

    function automatic logic [IDX_W-1:0] msg_target(input logic [VEC_W-1:0] v);
        vec_pfx_e p;
        p = vec_pfx_e'(v[VEC_W-1 -: 2]);
        case (p)
            PFX_HI:   return {1'b0, v[POS_W-1:0]};
            PFX_LO:   return {1'b1, v[POS_W-1:0]};
            PFX_MBX0: return IDX_W'(MBX_BASE) + IDX_W'(v[1:0]);
            default:  return IDX_W'(MBX_BASE + MBX_GRP) + IDX_W'(v[1:0]);
        endcase
    endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               msg_valid_i,
    input  logic [VEC_W-1:0]   msg_vec_i,
    input  logic               clr_valid_i,
    input  logic [MBX_N-1:0]   clr_bits_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] sticky_o
);
    logic [NUM_SRC-1:0] sticky_q, set_vec, clr_vec, raw;

    always_comb begin
        set_vec = '0;
        if (msg_valid_i)
            set_vec[msg_target(msg_vec_i)] = 1'b1;
    end

    always_comb begin
        clr_vec = '0;
        if (clr_valid_i)
            clr_vec[MBX_BASE +: MBX_N] = clr_bits_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sticky_q <= '0;
        else
            sticky_q <= (sticky_q & ~clr_vec) | set_vec;
    end

    assign raw      = src_i | sticky_q;
    assign status_o = {raw[NUM_SRC-1:HALF_W], raw[HALF_W-1:1], |raw[NUM_SRC-1:HALF_W]};
    assign sticky_o = sticky_q;

    // R8
    sticky_grow_chk: assert property (@(posedge clk) disable iff (rst)
        !msg_valid_i |=> ($countones(sticky_q) <= $countones($past(sticky_q))));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_route_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mask_we_i,
    input  logic                          map_we_i,
    input  logic                          half_i,
    input  logic [POS_W-1:0]              pos_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [NUM_SRC-1:0]            mask_o,
    output logic [NUM_SRC-1:0][MAP_W-1:0] map_o
);
    logic [NUM_SRC-1:0]            mask_q;
    logic [NUM_SRC-1:0][MAP_W-1:0] map_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (mask_we_i) begin
            if (half_i)
                mask_q[HALF_W +: HALF_W] <= wdata_i;
            else
                mask_q[0 +: HALF_W] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            map_q <= '0;
        else if (map_we_i)
            map_q[{half_i, pos_i}] <= wdata_i[MAP_W-1:0];
    end

    assign mask_o = mask_q;
    assign map_o  = map_q;

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_route_tree.sv
module irq_route_tree
    import irq_route_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            status_i,
    input  logic [NUM_SRC-1:0]            mask_i,
    input  logic [NUM_SRC-1:0][MAP_W-1:0] map_i,
    output logic [DEST_N-1:0]             dest_o
);
    logic [DEST_N-1:0] hit, dest_q;
    logic [NUM_SRC-1:0] live;

    assign live = status_i & ~mask_i;

    for (genvar k = 0; k < DEST_N; k++) begin : g_dest
        logic [NUM_SRC-1:0] sel;
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            assign sel[n] = (map_i[n] == MAP_W'(k));
        end
        assign hit[k] = |(live & sel);
    end

    always_ff @(posedge clk) begin
        if (rst)
            dest_q <= '0;
        else
            dest_q <= hit;
    end

    assign dest_o = dest_q;

    // R6
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (&mask_i) |=> (dest_o == '0));
endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub
    import irq_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [127:0]       src_i,
    input  logic               msg_valid_i,
    input  logic [7:0]         msg_vec_i,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [12:0]        addr_i,
    input  logic [63:0]        wdata_i,
    output logic [63:0]        rdata_o,
    output logic [7:0]         dest_o
);
    reg_sel_t                      sel;
    logic                          wr, rd;
    logic                          mask_we, map_we, clr_valid;
    logic [NUM_SRC-1:0]            status_w, sticky_w, mask_w;
    logic [NUM_SRC-1:0][MAP_W-1:0] map_w;
    logic [DATA_W-1:0]             rd_mux, rdata_q;

    assign sel       = decode_addr(addr_i);
    assign wr        = req_i & we_i;
    assign rd        = req_i & ~we_i;
    assign mask_we   = wr && (sel.kind == RG_MASK);
    assign map_we    = wr && (sel.kind == RG_MAP);
    assign clr_valid = wr && (sel.kind == RG_STATUS) && !sel.half;

    irq_status_bank u_status (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src_i),
        .msg_valid_i (msg_valid_i),
        .msg_vec_i   (msg_vec_i),
        .clr_valid_i (clr_valid),
        .clr_bits_i  (wdata_i[MBX_BASE +: MBX_N]),
        .status_o    (status_w),
        .sticky_o    (sticky_w)
    );

    irq_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .mask_we_i (mask_we),
        .map_we_i  (map_we),
        .half_i    (sel.half),
        .pos_i     (sel.pos),
        .wdata_i   (wdata_i),
        .mask_o    (mask_w),
        .map_o     (map_w)
    );

    irq_route_tree u_tree (
        .clk      (clk),
        .rst      (rst),
        .status_i (status_w),
        .mask_i   (mask_w),
        .map_i    (map_w),
        .dest_o   (dest_o)
    );

    always_comb begin
        case (sel.kind)
            RG_STATUS: rd_mux = sel.half ? status_w[HALF_W +: HALF_W] : status_w[0 +: HALF_W];
            RG_MASK:   rd_mux = sel.half ? mask_w[HALF_W +: HALF_W] : mask_w[0 +: HALF_W];
            RG_MAP:    rd_mux = DATA_W'(map_w[{sel.half, sel.pos}]);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd)
            rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;

    // R3
    cascade_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && sel.kind == RG_STATUS && !sel.half)
            |=> (rdata_o[0] == $past(|status_w[NUM_SRC-1:HALF_W])));

    // R10
    lo_status_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel.kind == RG_STATUS && sel.half && !msg_valid_i)
            |=> $stable(sticky_w[NUM_SRC-1:HALF_W]));

    // R10
    mbx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_valid && !msg_valid_i)
            |=> ((sticky_w[MBX_BASE +: MBX_N] & $past(wdata_i[MBX_BASE +: MBX_N])) == '0));
endmodule

// File: tb/irq_route_hub_bench.sv
module irq_route_hub_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] src_i = '0;
    logic         msg_valid_i = 1'b0;
    logic [7:0]   msg_vec_i = '0;
    logic         req_i = 1'b0;
    logic         we_i = 1'b0;
    logic [12:0]  addr_i = '0;
    logic [63:0]  wdata_i = '0;
    logic [63:0]  rdata_o;
    logic [7:0]   dest_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [127:0] m_src = '0, m_mask = '1, m_sticky = '0;
    logic [2:0]   m_map [128];

    irq_route_hub u_irq_route_hub (
        .clk(clk), .rst(rst), .src_i(src_i), .msg_valid_i(msg_valid_i),
        .msg_vec_i(msg_vec_i), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .dest_o(dest_o)
    );

    always #10 clk = ~clk;

    function automatic logic [127:0] f_status();
        logic [127:0] r;
        r = m_src | m_sticky;
        r[0] = |r[127:64];
        return r;
    endfunction

    function automatic logic [7:0] f_dest();
        logic [127:0] s;
        logic [7:0] d;
        s = f_status();
        d = '0;
        for (int n = 0; n < 128; n++)
            if (s[n] && !m_mask[n]) d[m_map[n]] = 1'b1;
        return d;
    endfunction

    function automatic int f_target(input logic [7:0] v);
        case (v[7:6])
            2'b00:   return int'(v[5:0]);
            2'b10:   return 64 + int'(v[5:0]);
            2'b01:   return 56 + int'(v[1:0]);
            default: return 60 + int'(v[1:0]);
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [12:0] a, input logic [63:0] d);
        @(negedge clk);
        req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
        @(negedge clk);
        req_i = 0; we_i = 0;
        if (a[11:0] == 12'h008) begin
            if (a[12]) m_mask[127:64] = d; else m_mask[63:0] = d;
        end else if (a[11:9] == 3'b001) begin
            m_map[{a[12], a[8:3]}] = d[2:0];
        end else if (a == 13'h0000) begin
            m_sticky[63:56] = m_sticky[63:56] & ~d[63:56];
        end
    endtask

    task automatic rd(input logic [12:0] a, output logic [63:0] d);
        @(negedge clk);
        req_i = 1; we_i = 0; addr_i = a;
        @(negedge clk);
        req_i = 0;
        d = rdata_o;
    endtask

    task automatic send(input logic [7:0] v);
        @(negedge clk);
        msg_valid_i = 1; msg_vec_i = v;
        @(negedge clk);
        msg_valid_i = 0;
        m_sticky[f_target(v)] = 1'b1;
    endtask

    task automatic drive_src(input logic [127:0] v);
        @(negedge clk);
        src_i = v;
        m_src = v;
    endtask

    task automatic chk_status(input string req);
        logic [63:0] d;
        logic [127:0] s;
        s = f_status();
        rd(13'h0000, d); chk(req, d, s[63:0]);
        rd(13'h1000, d); chk(req, d, s[127:64]);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'h5eed_1480));
        for (int n = 0; n < 128; n++) m_map[n] = '0;
        idle(3);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 dest", 64'(dest_o), 64'h0);
        rd(13'h0008, d); chk("R1 mask hi", d, '1);
        rd(13'h1008, d); chk("R1 mask lo", d, '1);
        rd(13'h1200 + 13'(8 * 9), d); chk("R1 map", d, 0);
        chk_status("R1 status");

        // R5 all masked, sources active
        drive_src('1); idle(2);
        chk("R5 masked dest", 64'(dest_o), 0);
        drive_src('0);

        // R2 half offset and register map
        wr(13'h0008, 64'hA5A5_0000_FFFF_1234);
        wr(13'h1008, 64'h0F0F_1111_2222_3333);
        rd(13'h0008, d); chk("R2 mask hi", d, 64'hA5A5_0000_FFFF_1234);
        rd(13'h1008, d); chk("R2 mask lo", d, 64'h0F0F_1111_2222_3333);
        wr(13'h1200 + 13'(8 * 3), 64'h5);
        rd(13'h1200 + 13'(8 * 3), d); chk("R2 map lo", d, 64'h5);
        rd(13'h0200 + 13'(8 * 3), d); chk("R2 map hi", d, 64'h0);
        rd(13'h0100, d); chk("R2 unmapped", d, 64'h0);

        // R3 cascade
        drive_src(128'h1); idle(1);
        chk_status("R3 src0 ignored");
        drive_src(128'h1 << 71); idle(1);
        chk_status("R3 cascade set");
        drive_src('0);

        // R7 latency: position 5 to code 2
        wr(13'h0008, 64'h0);
        wr(13'h0200 + 13'(8 * 5), 64'h2);
        idle(2);
        chk("R7 before", 64'(dest_o), 64'(f_dest()));
        drive_src(128'h1 << 5);
        @(negedge clk);
        chk("R7 one edge", 64'(dest_o), 64'h04);
        chk("R4 position", 64'(dest_o), 64'(f_dest()));
        drive_src('0);

        // R8 R9 message prefixes
        send(8'h07);  send(8'h8C);  send(8'h42);  send(8'hC3);  send(8'h00);
        idle(1);
        chk_status("R8 R9 prefixes");
        chk("R9 mbx bits", 64'(m_sticky[63:56]), 64'h84);

        // R10 low status write ignored, high clears mailbox only
        wr(13'h1000, '1);
        wr(13'h0000, 64'h0400_0000_0000_0080);
        chk_status("R10 w1c");
        // R10 set wins on collision at bit 57, bit 58 cleared
        send(8'h41);
        @(negedge clk);
        req_i = 1; we_i = 1; addr_i = 13'h0000; wdata_i = 64'h0600_0000_0000_0000;
        msg_valid_i = 1; msg_vec_i = 8'h41;
        @(negedge clk);
        req_i = 0; we_i = 0; msg_valid_i = 0;
        m_sticky[58] = 1'b0;
        m_sticky[57] = 1'b1;
        chk_status("R10 set wins");

        // R6 random routing
        for (int it = 0; it < 16; it++) begin
            wr(13'h0008, {$urandom, $urandom});
            wr(13'h1008, {$urandom, $urandom});
            for (int n = 0; n < 128; n++)
                wr({n[6], 3'b001, n[5:0], 3'b000}, 64'($urandom_range(7)));
            if (it % 4 == 0) wr(13'h1008, '1);
            if (it % 4 == 1) wr(13'h1008, '0);
            send(8'($urandom));
            drive_src({$urandom, $urandom, $urandom, $urandom} & {4{$urandom}});
            idle(2);
            chk("R6 dest", 64'(dest_o), 64'(f_dest()));
            chk_status("R4 status");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule